// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Receiver

This block receives serial words when another device drives the shift clock. It has no bit-rate generator of its own. The shift clock and the data line come in asynchronously. Both are brought into the system clock domain, and data is taken on each rising edge of the synchronised shift clock, least significant bit first. The bits build up in a shift register. When the last bit of a frame arrives, the word moves into a holding buffer and a word-ready flag sets. Because every bit is paced by the external clock, a word can finish while the core that owns the block is asleep. An interrupt request formed from the flag and an enable can then wake that core.

A frame is eight data bits, or nine when the nine-bit mode input is high. The ninth bit is reported next to an overrun indication on the status outputs, and it is captured in the same cycle as the data byte. A word that completes while the buffer still holds an unread word is thrown away and sets the overrun bit. Reception then stops until software drops the continuous-receive enable. Dropping that enable also throws away any word that is only partly received. The single-receive enable is accepted at the boundary but has no effect, because this block only ever works as a clock slave.

Top module: `sync_slave_rx`

## Requirements
- R1: The receiver samples bits only while `port_en`=1, `sync_mode`=1, `master_sel`=0 and `cont_rx_en`=1. If any of these conditions is not met, shift-clock edges are not counted and no word completes.
- R2: `single_rx_en` has no effect on any output.
- R3: Bits are taken on rising shift-clock edges, least significant first. On the edge that carries the last bit of a frame, the data bits move to `rx_data` and `rx_ready` sets. These outputs change at the third system-clock edge after the first system-clock edge at which the shift clock is seen high.
- R4: `rx_irq` equals `rx_ready` AND `rx_ie`. It is registered and appears in the same cycle as the flag.
- R5: With `nine_bit_en`=1 a frame is nine bits. The ninth received bit appears on `stat_bit9` in the same cycle as its data byte. In eight-bit mode `stat_bit9` is loaded with 0.
- R6: A `buf_rd` pulse clears `rx_ready` at the next edge. If a word completes in the same cycle as the read, the new word loads and the flag stays set.
- R7: If a word completes while `rx_ready`=1 and no read occurs in that cycle, `stat_ovr` sets and `rx_data` and `stat_bit9` keep the old word. Later words are not received until the error is cleared.
- R8: `cont_rx_en`=0 clears `stat_ovr` at the next edge and restarts the bit count, so a partly received word is lost.
- R9: Synchronous active-high reset clears `rx_data`, `rx_ready`, `rx_irq`, `stat_bit9` and `stat_ovr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sck | input | 1 | Externally driven shift clock (asynchronous) |
| ser_in | input | 1 | Serial data line (asynchronous) |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | 1 selects synchronous operation |
| master_sel | input | 1 | 1 = master, 0 = slave; reception needs 0 |
| cont_rx_en | input | 1 | Continuous receive enable; low clears errors |
| single_rx_en | input | 1 | Single receive enable; ignored |
| nine_bit_en | input | 1 | 1 selects nine-bit frames |
| rx_ie | input | 1 | Receive interrupt enable |
| buf_rd | input | 1 | Buffer read strobe, one cycle |
| rx_data | output | DATA_W | Received data buffer |
| rx_ready | output | 1 | Word-ready flag |
| rx_irq | output | 1 | Interrupt / wake request |
| stat_bit9 | output | 1 | Ninth bit of the buffered word |
| stat_ovr | output | 1 | Overrun error |

## Verification
The completion outputs (`rx_data`, `rx_ready`, `stat_bit9`, `stat_ovr` and `rx_irq`) are due at the third system-clock edge after the shift clock is first sampled high. That delay comes from two synchroniser stages, the edge detector and the buffer stage. A buffer read clears the flag one edge later, and dropping the continuous enable clears the overrun bit one edge later. The bench keeps a history of the sampled shift-clock and data levels. It advances its own model at every rising edge, applying exactly these delays, and compares all outputs at the falling edge in between. Directed checks taken after each scenario also compare the buffer against the value that was serialised.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned RX_DATA_W  = 8;
  localparam int unsigned RX_SYNC_N  = 2;

  typedef struct packed {
    logic valid;
    logic bit9;
  } rx_word_meta_t;
endpackage

// File: rtl/sck_sync.sv
module sck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_async,
  input  logic sd_async,
  output logic sck_rise,
  output logic sd_synced
);
  logic [STAGES-1:0] sck_chain;
  logic [STAGES-1:0] sd_chain;
  logic              sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_chain[0] <= 1'b0;
      sd_chain[0]  <= 1'b0;
    end else begin
      sck_chain[0] <= sck_async;
      sd_chain[0]  <= sd_async;
    end
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_chain[g] <= 1'b0;
          sd_chain[g]  <= 1'b0;
        end else begin
          sck_chain[g] <= sck_chain[g-1];
          sd_chain[g]  <= sd_chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_last <= 1'b0;
    else     sck_last <= sck_chain[STAGES-1];
  end

  assign sck_rise  = sck_chain[STAGES-1] & ~sck_last;
  assign sd_synced = sd_chain[STAGES-1];

  // R3: an edge pulse lasts exactly one cycle
  p_rise_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    sck_rise |=> !sck_rise);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              nine_bit,
  input  logic              bit_stb,
  input  logic              bit_val,
  output logic [DATA_W-1:0] word_q,
  output rx_word_meta_t     meta_q
);
  localparam int unsigned SH_W  = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  sh_q;
  logic [SH_W-1:0]  sh_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  assign last_idx = nine_bit ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

  always_comb begin
    sh_nxt = sh_q;
    sh_nxt[cnt_q] = bit_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      word_q <= '0;
      meta_q <= '0;
    end else if (!run_en) begin
      cnt_q        <= '0;
      meta_q.valid <= 1'b0;
    end else if (bit_stb) begin
      sh_q <= sh_nxt;
      if (cnt_q >= last_idx) begin
        cnt_q        <= '0;
        word_q       <= sh_nxt[DATA_W-1:0];
        meta_q.valid <= 1'b1;
        meta_q.bit9  <= nine_bit & sh_nxt[DATA_W];
      end else begin
        cnt_q        <= cnt_q + 1'b1;
        meta_q.valid <= 1'b0;
      end
    end else begin
      meta_q.valid <= 1'b0;
    end
  end

  // R1: a finished word is only produced while reception was enabled
  p_word_needs_enable_r1: assert property (@(posedge clk) disable iff (rst)
    meta_q.valid |-> $past(run_en));
  // R3: the bit index never passes the longest frame
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DATA_W));
  // R8: with reception off, no word completes
  p_off_no_word_r8: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !meta_q.valid);
endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_in,
  input  rx_word_meta_t     meta_in,
  input  logic              rd_stb,
  input  logic              err_keep,
  input  logic              irq_en,
  output logic [DATA_W-1:0] data_q,
  output logic              bit9_q,
  output logic              flag_q,
  output logic              ovr_q,
  output logic              irq_q
);
  logic accept;
  logic collide;
  logic flag_nxt;

  assign accept  = meta_in.valid & (~flag_q | rd_stb);
  assign collide = meta_in.valid & flag_q & ~rd_stb;

  always_comb begin
    flag_nxt = flag_q;
    if (accept)      flag_nxt = 1'b1;
    else if (rd_stb) flag_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bit9_q <= 1'b0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (accept) begin
        data_q <= word_in;
        bit9_q <= meta_in.bit9;
      end
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt & irq_en;
      if (!err_keep)    ovr_q <= 1'b0;
      else if (collide) ovr_q <= 1'b1;
    end
  end

  // R4: interrupt request tracks flag and enable
  p_irq_follows_flag_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q & $past(irq_en)));
  // R6: a read with no new word clears the flag
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !meta_in.valid) |=> !flag_q);
  // R7: while overrun is latched the buffer is frozen
  p_ovr_keeps_buffer_r7: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> $stable(data_q) && $stable(bit9_q));
  // R8: dropping the continuous enable clears the error
  p_clear_drops_ovr_r8: assert property (@(posedge clk) disable iff (rst)
    !err_keep |=> !ovr_q);
endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx
  import sync_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = RX_DATA_W,
  parameter int unsigned SYNC_STAGES = RX_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_sck,
  input  logic              ser_in,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              master_sel,
  input  logic              cont_rx_en,
  input  logic              single_rx_en,
  input  logic              nine_bit_en,
  input  logic              rx_ie,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              stat_bit9,
  output logic              stat_ovr
);
  logic              sck_rise;
  logic              sd_s;
  logic              rx_on;
  logic              run_en;
  logic [DATA_W-1:0] sh_word;
  rx_word_meta_t     sh_meta;
  logic              unused_single;

  // Slave-only receiver: the single-receive request carries no meaning here.
  assign unused_single = single_rx_en;

  assign rx_on  = port_en & sync_mode & ~master_sel & cont_rx_en;
  assign run_en = rx_on & ~stat_ovr;

  sck_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .sck_async (ext_sck),
    .sd_async  (ser_in),
    .sck_rise  (sck_rise),
    .sd_synced (sd_s)
  );

  rx_shifter #(.DATA_W(DATA_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .nine_bit (nine_bit_en),
    .bit_stb  (sck_rise),
    .bit_val  (sd_s),
    .word_q   (sh_word),
    .meta_q   (sh_meta)
  );

  rx_holding #(.DATA_W(DATA_W)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .word_in  (sh_word),
    .meta_in  (sh_meta),
    .rd_stb   (buf_rd),
    .err_keep (cont_rx_en),
    .irq_en   (rx_ie),
    .data_q   (rx_data),
    .bit9_q   (stat_bit9),
    .flag_q   (rx_ready),
    .ovr_q    (stat_ovr),
    .irq_q    (rx_irq)
  );

  // R7: once overrun is latched no new word is taken
  p_blocked_after_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_ovr && $past(stat_ovr)) |-> !sh_meta.valid);
endmodule

// File: tb/sync_slave_rx_tb_top.sv
`timescale 1ns/1ps
module sync_slave_rx_tb_top;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_sck = 1'b0, ser_in = 1'b0;
  logic port_en = 1'b0, sync_mode = 1'b0, master_sel = 1'b0, cont_rx_en = 1'b0;
  logic single_rx_en = 1'b0, nine_bit_en = 1'b0, rx_ie = 1'b0, buf_rd = 1'b0;
  logic [DW-1:0] rx_data;
  logic rx_ready, rx_irq, stat_bit9, stat_ovr;

  always #2.5 clk = ~clk;

  sync_slave_rx dut_i (
    .clk(clk), .rst(rst), .ext_sck(ext_sck), .ser_in(ser_in),
    .port_en(port_en), .sync_mode(sync_mode), .master_sel(master_sel),
    .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en),
    .nine_bit_en(nine_bit_en), .rx_ie(rx_ie), .buf_rd(buf_rd),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .stat_bit9(stat_bit9), .stat_ovr(stat_ovr)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Behavioural reference: sampled-level history and plain integers.
  int hs[$];
  int hd[$];
  int m_cnt = 0, m_vld = 0, m_w9 = 0;
  int m_bits = 0, m_word = 0;
  int m_data = 0, m_b9 = 0, m_flag = 0, m_ovr = 0, m_irq = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin hs.push_back(0); hd.push_back(0); end
  end

  always @(posedge clk) begin
    int rise, dbit, last, on, nf, nvld;
    if (rst) begin
      hs = '{0, 0, 0, 0}; hd = '{0, 0, 0, 0};
      m_cnt = 0; m_vld = 0; m_w9 = 0; m_bits = 0; m_word = 0;
      m_data = 0; m_b9 = 0; m_flag = 0; m_ovr = 0; m_irq = 0;
    end else begin
      // hs[0] = level seen one edge ago, hs[1] two edges ago, ...
      rise = (hs[1] == 1 && hs[2] == 0) ? 1 : 0;
      dbit = hd[1];
      on = (port_en && sync_mode && !master_sel && cont_rx_en && m_ovr == 0) ? 1 : 0;
      // buffer stage, using the previous completion
      nf = m_flag;
      if (m_vld == 1 && (m_flag == 0 || buf_rd)) begin
        m_data = m_word; m_b9 = m_w9; nf = 1;
      end else if (buf_rd) nf = 0;
      if (!cont_rx_en) m_ovr = 0;
      else if (m_vld == 1 && m_flag == 1 && !buf_rd) m_ovr = 1;
      m_flag = nf;
      m_irq = (nf == 1 && rx_ie) ? 1 : 0;
      // bit assembly stage
      nvld = 0;
      last = nine_bit_en ? DW : DW - 1;
      if (on == 0) m_cnt = 0;
      else if (rise == 1) begin
        if (dbit == 1) m_bits = m_bits | (1 << m_cnt);
        else           m_bits = m_bits & ~(1 << m_cnt);
        if (m_cnt >= last) begin
          nvld = 1; m_cnt = 0;
          m_word = m_bits & ((1 << DW) - 1);
          m_w9 = (nine_bit_en && ((m_bits >> DW) & 1) == 1) ? 1 : 0;
        end else m_cnt = m_cnt + 1;
      end
      m_vld = nvld;
      hs.push_front(int'(ext_sck)); void'(hs.pop_back());
      hd.push_front(int'(ser_in));  void'(hd.pop_back());
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      cmp("R3", "rx_data",   int'(rx_data),   m_data);
      cmp("R3", "rx_ready",  int'(rx_ready),  m_flag);
      cmp("R4", "rx_irq",    int'(rx_irq),    m_irq);
      cmp("R5", "stat_bit9", int'(stat_bit9), m_b9);
      cmp("R7", "stat_ovr",  int'(stat_ovr),  m_ovr);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int val, int nbits, bit wiggle);
    for (int b = 0; b < nbits; b++) begin
      @(negedge clk);
      ext_sck = 1'b0; ser_in = ((val >> b) & 1) == 1;
      if (wiggle) single_rx_en = ~single_rx_en;
      idle(4);
      ext_sck = 1'b1;
      idle(4);
    end
    @(negedge clk); ext_sck = 1'b0;
    idle(6);
  endtask

  task automatic read_buf();
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
    idle(2);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    idle(4);
    @(negedge clk);
    // R9: reset state
    cmp("R9", "reset rx_data",  int'(rx_data),  0);
    cmp("R9", "reset rx_ready", int'(rx_ready), 0);
    cmp("R9", "reset stat_ovr", int'(stat_ovr), 0);
    rst = 1'b0;
    port_en = 1; sync_mode = 1; master_sel = 0; cont_rx_en = 1; rx_ie = 1;
    idle(4);

    // R3, R2, R4: eight-bit word with the single-receive input wiggling
    send(8'hA5, 8, 1'b1);
    cmp("R3", "word A5", int'(rx_data), 8'hA5);
    cmp("R2", "flag with single wiggle", int'(rx_ready), 1);
    cmp("R4", "irq on", int'(rx_irq), 1);
    rx_ie = 0; idle(2);
    cmp("R4", "irq masked", int'(rx_irq), 0);
    rx_ie = 1;

    // R6: reading clears the flag
    read_buf();
    cmp("R6", "flag after read", int'(rx_ready), 0);

    // R1: master select and port disable block reception
    master_sel = 1; send(8'h3C, 8, 1'b0);
    cmp("R1", "master blocks", int'(rx_ready), 0);
    master_sel = 0; port_en = 0; send(8'hC3, 8, 1'b0);
    cmp("R1", "port off blocks", int'(rx_ready), 0);
    cmp("R1", "buffer unchanged", int'(rx_data), 8'hA5);
    port_en = 1; idle(2);

    // R5: nine-bit frame
    nine_bit_en = 1; send(9'h13C, 9, 1'b0);
    cmp("R5", "nine-bit data", int'(rx_data), 8'h3C);
    cmp("R5", "ninth bit", int'(stat_bit9), 1);
    read_buf();
    nine_bit_en = 0; send(8'h81, 8, 1'b0);
    cmp("R5", "eight-bit ninth zero", int'(stat_bit9), 0);
    read_buf();

    // R7: overrun keeps the old word and blocks reception
    send(8'h11, 8, 1'b0);
    send(8'h22, 8, 1'b0);
    cmp("R7", "overrun set", int'(stat_ovr), 1);
    cmp("R7", "old word kept", int'(rx_data), 8'h11);
    read_buf();
    send(8'h44, 8, 1'b0);
    cmp("R7", "blocked no flag", int'(rx_ready), 0);
    cmp("R7", "blocked data", int'(rx_data), 8'h11);

    // R8: clearing continuous enable clears overrun and drops partial word
    cont_rx_en = 0; idle(2);
    cmp("R8", "overrun cleared", int'(stat_ovr), 0);
    cont_rx_en = 1; idle(2);
    send(8'h07, 3, 1'b0);
    cont_rx_en = 0; idle(3); cont_rx_en = 1; idle(2);
    send(8'h5A, 8, 1'b0);
    cmp("R8", "fresh word after drop", int'(rx_data), 8'h5A);
    cmp("R8", "flag after drop", int'(rx_ready), 1);

    // R6: read strobe held across completion keeps the flag set
    @(negedge clk); buf_rd = 1'b1;
    send(8'h96, 8, 1'b0);
    buf_rd = 1'b0; idle(2);
    cmp("R6", "read during completion data", int'(rx_data), 8'h96);
    cmp("R7", "no overrun when read", int'(stat_ovr), 0);

    idle(4);
    summary();
  end
endmodule